// File: doc/BRIEF.md
# Pin Controller with Atomic Set and Clear

This block drives up to 54 general-purpose pins from a plain 32-bit register bus. Software picks each pin's mode through a 3-bit field. The fields are packed ten to a select word. A pin's output level is never written directly. One register raises the levels of the pins whose bits are written as 1, and another lowers them. Because of this, firmware never has to read a word, modify it and write it back to change one pin.

Each pin has an output latch, and the latch follows set and clear writes whatever the pin's mode. The mode only decides whether the pin is driven. When a pin moves from input to output, it drives the level left by the most recent set or clear at once. Pin states enter through a two-flop synchroniser and can be read back through two level words.

The bus carries a word address, a write strobe, write data and a read strobe. Read data appears one cycle after the read strobe.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: After reset, every mode field is 000 (input), `pin_oe` and `pin_out` are all zero, and `bus_rdata` is zero.
- R2: Pin n keeps its mode in select word n/10, at byte offset 4*(n/10), bits [3*(n%10)+2 : 3*(n%10)]. Reading a select word returns its stored fields. Bits 31:30, and the slots of pins that do not exist, read as zero.
- R3: `pin_oe[n]` is high exactly when pin n's field holds 001. Every other code, 000 and 010 to 111, leaves the pin undriven.
- R4: Writing the set words raises the latch of each pin whose data bit is 1, visible on `pin_out` one cycle after the write. Offset 0x1C covers pins 0 to 31 (bit = pin). Offset 0x20 covers pins 32 to 53 (bit = pin-32). Data bits that are 0 change nothing.
- R5: Writing the clear words lowers the latch of each pin whose data bit is 1. Offset 0x28 covers pins 0 to 31 and offset 0x2C covers pins 32 to 53, with the same bit mapping as the set words. Data bits that are 0 change nothing.
- R6: Set and clear writes update the latch and `pin_out` regardless of the pin's mode. Switching a pin to output makes it driven with the latched level straight away.
- R7: Reads of the set and clear words return zero.
- R8: Offset 0x34 returns pins 0 to 31 and offset 0x38 returns pins 32 to 53 in bits 21:0, with higher bits zero. The values pass through a two-flop synchroniser, so a change on `pin_in` is seen by a read strobe no earlier than the second clock edge after the change. Writes to these words change nothing.
- R9: Offsets outside the map (0x18, 0x24, 0x30, 0x3C and up) read zero. Writes to them change no output and no register.
- R10: `bus_rdata` is zero in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 54 | Raw pin levels |
| pin_out | output | 54 | Output latch per pin |
| pin_oe | output | 54 | Drive enable per pin |

## Verification
The assertions assume at most one strobe at a time and a stable address while a strobe is high. They also assume that an output or enable changes only in the cycle after a write. The bench drives exactly one strobe per operation, for a single cycle, from the falling edge, and holds `pin_in` steady for two cycles before any level read. The random mix covers select, set, clear, unmapped and level traffic. A bench model of the fields and latches gives the expected values, so the latch keeps changing under input mode while the mode codes sweep all eight values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_W        = 32;
  localparam int unsigned MODE_W       = 3;
  localparam int unsigned PINS_PER_SEL = 10;
  localparam int unsigned SEL_FIELD_W  = PINS_PER_SEL * MODE_W;

  // word indices (byte offset / 4); behaviour depends on these positions
  localparam int unsigned SEL_WORD0 = 0;
  localparam int unsigned SET_WORD0 = 7;
  localparam int unsigned CLR_WORD0 = 10;
  localparam int unsigned LEV_WORD0 = 13;

  localparam logic [MODE_W-1:0] MODE_INPUT  = 3'b000;
  localparam logic [MODE_W-1:0] MODE_OUTPUT = 3'b001;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_pkg::*;
#(
  parameter int unsigned WORD_W    = 6,
  parameter int unsigned NUM_SEL   = 6,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic [WORD_W-1:0]    word,
  output logic [NUM_SEL-1:0]   sel_hit,
  output logic [NUM_BANKS-1:0] set_hit,
  output logic [NUM_BANKS-1:0] clr_hit,
  output logic [NUM_BANKS-1:0] lev_hit
);
  always_comb begin
    for (int i = 0; i < NUM_SEL; i++) begin
      sel_hit[i] = (word == WORD_W'(SEL_WORD0 + i));
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      set_hit[b] = (word == WORD_W'(SET_WORD0 + b));
      clr_hit[b] = (word == WORD_W'(CLR_WORD0 + b));
      lev_hit[b] = (word == WORD_W'(LEV_WORD0 + b));
    end
  end
endmodule

// File: rtl/gpio_mode_regs.sv
module gpio_mode_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned NUM_SEL  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [NUM_SEL-1:0]       sel_hit,
  input  logic [SEL_FIELD_W-1:0]   wdata,
  output logic [NUM_SEL*BUS_W-1:0] sel_rd,
  output logic [NUM_PINS-1:0]      pin_oe
);
  localparam int unsigned PAD_W = BUS_W - SEL_FIELD_W;

  for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
    localparam int unsigned REG_IDX = gp / PINS_PER_SEL;
    localparam int unsigned SLOT    = gp % PINS_PER_SEL;
    logic              mode_en;
    logic [MODE_W-1:0] mode_d;
    logic [MODE_W-1:0] mode_q;

    assign mode_en = wr_en & sel_hit[REG_IDX];

    always_comb begin
      mode_d = wdata[SLOT*MODE_W +: MODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= MODE_INPUT;
      end else if (mode_en) begin
        mode_q <= mode_d;
      end
    end

    assign pin_oe[gp] = (mode_q == MODE_OUTPUT);
    assign sel_rd[REG_IDX*BUS_W + SLOT*MODE_W +: MODE_W] = mode_q;
  end

  for (genvar gr = 0; gr < NUM_SEL; gr++) begin : g_word
    assign sel_rd[gr*BUS_W + SEL_FIELD_W +: PAD_W] = '0;
    for (genvar gs = 0; gs < PINS_PER_SEL; gs++) begin : g_slot
      if (gr*PINS_PER_SEL + gs >= NUM_PINS) begin : g_empty
        assign sel_rd[gr*BUS_W + gs*MODE_W +: MODE_W] = '0;
      end
    end
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 54,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_BANKS-1:0] set_hit,
  input  logic [NUM_BANKS-1:0] clr_hit,
  input  logic [BUS_W-1:0]     wdata,
  output logic [NUM_PINS-1:0]  out_q
);
  logic [NUM_PINS-1:0] set_mask;
  logic [NUM_PINS-1:0] clr_mask;
  logic [NUM_PINS-1:0] out_d;
  logic                out_en;

  for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_mask
    localparam int unsigned BANK = gp / BUS_W;
    localparam int unsigned BIT  = gp % BUS_W;
    assign set_mask[gp] = wr_en & set_hit[BANK] & wdata[BIT];
    assign clr_mask[gp] = wr_en & clr_hit[BANK] & wdata[BIT];
  end

  assign out_en = |(set_mask | clr_mask);

  // clear takes priority over set when both hit one pin
  always_comb begin
    out_d = (out_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_sync
);
  logic [NUM_PINS-1:0] stage_q [STAGES];

  for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
    logic [NUM_PINS-1:0] stage_d;
    if (gs == 0) begin : g_first
      assign stage_d = pin_in;
    end else begin : g_next
      assign stage_d = stage_q[gs-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[gs] <= '0;
      end else begin
        stage_q[gs] <= stage_d;
      end
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 54,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic                bus_rd,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int unsigned NUM_SEL   = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL;
  localparam int unsigned NUM_BANKS = (NUM_PINS + BUS_W - 1) / BUS_W;
  localparam int unsigned WORD_W    = ADDR_W - 2;

  logic [NUM_SEL-1:0]         sel_hit;
  logic [NUM_BANKS-1:0]       set_hit;
  logic [NUM_BANKS-1:0]       clr_hit;
  logic [NUM_BANKS-1:0]       lev_hit;
  logic [NUM_SEL*BUS_W-1:0]   sel_rd;
  logic [NUM_PINS-1:0]        pin_sync;
  logic [NUM_BANKS*BUS_W-1:0] lev_flat;
  logic [BUS_W-1:0]           rdata_d;
  logic [BUS_W-1:0]           rdata_q;

  gpio_addr_decode #(
    .WORD_W   (WORD_W),
    .NUM_SEL  (NUM_SEL),
    .NUM_BANKS(NUM_BANKS)
  ) u_decode (
    .word   (bus_addr[ADDR_W-1:2]),
    .sel_hit(sel_hit),
    .set_hit(set_hit),
    .clr_hit(clr_hit),
    .lev_hit(lev_hit)
  );

  gpio_mode_regs #(
    .NUM_PINS(NUM_PINS),
    .NUM_SEL (NUM_SEL)
  ) u_modes (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .sel_hit(sel_hit),
    .wdata  (bus_wdata[SEL_FIELD_W-1:0]),
    .sel_rd (sel_rd),
    .pin_oe (pin_oe)
  );

  gpio_out_latch #(
    .NUM_PINS (NUM_PINS),
    .NUM_BANKS(NUM_BANKS)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .set_hit(set_hit),
    .clr_hit(clr_hit),
    .wdata  (bus_wdata),
    .out_q  (pin_out)
  );

  gpio_in_sync #(
    .NUM_PINS(NUM_PINS),
    .STAGES  (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .pin_sync(pin_sync)
  );

  always_comb begin
    lev_flat = '0;
    lev_flat[NUM_PINS-1:0] = pin_sync;
  end

  // set, clear and unmapped words contribute nothing, so they read zero
  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      for (int i = 0; i < NUM_SEL; i++) begin
        if (sel_hit[i]) rdata_d = rdata_d | sel_rd[i*BUS_W +: BUS_W];
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (lev_hit[b]) rdata_d = rdata_d | lev_flat[b*BUS_W +: BUS_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_setclr_ctrl_chk.sv
module gpio_setclr_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned WORD_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [WORD_W-1:0]   word,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic                wbit0,
  input logic [BUS_W-1:0]    bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  logic setclr_word;
  logic hole_word;

  assign setclr_word = (word == WORD_W'(SET_WORD0)) || (word == WORD_W'(SET_WORD0 + 1)) ||
                       (word == WORD_W'(CLR_WORD0)) || (word == WORD_W'(CLR_WORD0 + 1));
  assign hole_word   = (word == WORD_W'(6)) || (word == WORD_W'(9)) ||
                       (word == WORD_W'(12)) || (word >= WORD_W'(15));

  AST_OE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != $past(pin_oe)) |-> $past(bus_wr)); // R3

  AST_OUT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out != $past(pin_out)) |-> $past(bus_wr)); // R4

  AST_CLR_LOWERS_PIN0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wbit0 && (word == WORD_W'(CLR_WORD0))) |=> !pin_out[0]); // R5

  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && setclr_word) |=> (bus_rdata == '0)); // R7

  AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hole_word) |=> (bus_rdata == '0)); // R9

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0)); // R10
endmodule

bind gpio_setclr_ctrl gpio_setclr_ctrl_chk #(
  .NUM_PINS(NUM_PINS),
  .WORD_W  (ADDR_W - 2)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .word     (bus_addr[ADDR_W-1:2]),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .wbit0    (bus_wdata[0]),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe)
);

// File: tb/test_gpio_setclr_ctrl.sv
module test_gpio_setclr_ctrl;
  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic          bus_rd;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  always #4 clk = ~clk;

  gpio_setclr_ctrl i_gpio_setclr_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [2:0]    m_mode [NP];
  logic [NP-1:0] m_lat;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sel(input int idx);
    logic [31:0] r = '0;
    for (int p = 0; p < NP; p++) if (p / 10 == idx) r[3*(p%10) +: 3] = m_mode[p];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = (m_mode[p] == 3'b001);
    return r;
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    int w = int'(a[7:2]);
    if (w <= 5) return exp_sel(w);
    if (w == 13) return pin_in[31:0];
    if (w == 14) return {10'b0, pin_in[53:32]};
    return '0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int w = int'(a[7:2]);
    if (w <= 5) begin
      for (int p = 0; p < NP; p++) if (p / 10 == w) m_mode[p] = d[3*(p%10) +: 3];
    end
    if (w == 7)  m_lat[31:0]  = m_lat[31:0] | d;
    if (w == 8)  m_lat[53:32] = m_lat[53:32] | d[21:0];
    if (w == 10) m_lat[31:0]  = m_lat[31:0] & ~d;
    if (w == 11) m_lat[53:32] = m_lat[53:32] & ~d[21:0];
  endtask

  task automatic check_ports(input string tag);
    chk({tag, " pin_out"}, 64'(pin_out), 64'(m_lat));
    chk({tag, " pin_oe"}, 64'(pin_oe), 64'(exp_oe()));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    logic [31:0] d;
    logic [31:0] e;
    e = exp_word(a);
    rd(a, d);
    chk(tag, 64'(d), 64'(e));
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0] holes [5];
    holes = '{8'h18, 8'h24, 8'h30, 8'h3C, 8'hFC};
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0; pin_in = '0;
    for (int p = 0; p < NP; p++) m_mode[p] = 3'b000;
    m_lat = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", 64'(pin_oe), 64'd0);
    chk("R1 pin_out", 64'(pin_out), 64'd0);
    chk("R1 rdata", 64'(bus_rdata), 64'd0);
    rd_chk("R1 sel0", 8'h00);

    // R2 field position: pin 4 at bits 14:12 of word 0
    wr(8'h00, 32'h0000_1000);
    check_ports("R2 pin4 output");
    chk("R3 oe pin4", 64'(pin_oe[4]), 64'd1);
    rd_chk("R2 sel0 readback", 8'h00);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R2 sel5 unused slots zero", 8'h14);
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R2 sel1 top bits zero", 8'h04);
    check_ports("R3 code 111 undriven");
    wr(8'h04, 32'h0); wr(8'h14, 32'h0);

    // R3 sweep all eight codes on pin 20
    for (int c = 0; c < 8; c++) begin
      wr(8'h08, 32'(c));
      chk($sformatf("R3 code %0d pin20 oe", c), 64'(pin_oe[20]), 64'(c == 1));
    end
    wr(8'h08, 32'h0);

    // R6 latch moves while input, driven once switched to output
    wr(8'h1C, 32'h0000_0080);
    chk("R6 latch under input", 64'(pin_out[7]), 64'd1);
    chk("R6 still undriven", 64'(pin_oe[7]), 64'd0);
    wr(8'h00, 32'h0020_1000);
    chk("R6 driven with latched level", 64'({pin_oe[7], pin_out[7]}), 64'd3);

    // R4 / R5 set and clear, zero bits inert
    wr(8'h1C, 32'h0000_0010);
    check_ports("R4 set pin4");
    wr(8'h1C, 32'h0);
    check_ports("R4 zero bits no effect");
    wr(8'h28, 32'h0000_0010);
    check_ports("R5 clear pin4");
    wr(8'h28, 32'h0);
    check_ports("R5 zero bits no effect");
    wr(8'h20, 32'h0020_0000);
    chk("R4 bank1 pin53 set", 64'(pin_out[53]), 64'd1);
    wr(8'h2C, 32'h0020_0000);
    chk("R5 bank1 pin53 clear", 64'(pin_out[53]), 64'd0);

    // R7 set/clear read zero
    wr(8'h1C, 32'hA5A5_A5A5);
    rd_chk("R7 set0 reads zero", 8'h1C);
    rd_chk("R7 set1 reads zero", 8'h20);
    rd_chk("R7 clr0 reads zero", 8'h28);
    rd_chk("R7 clr1 reads zero", 8'h2C);

    // R9 unmapped offsets
    foreach (holes[i]) begin
      wr(holes[i], 32'hFFFF_FFFF);
      check_ports("R9 hole write inert");
      rd_chk("R9 hole reads zero", holes[i]);
    end
    rd_chk("R9 sel0 untouched", 8'h00);

    // R8 two-flop synchroniser latency and ignored writes
    pin_in = 54'h2A_5A5A_1234_8001;
    rd(8'h34, d);
    chk("R8 one edge too early", 64'(d), 64'd0);
    rd(8'h34, d);
    chk("R8 after two edges", 64'(d), 64'h1234_8001);
    rd_chk("R8 level bank1", 8'h38);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    check_ports("R8 level write inert");
    rd_chk("R8 level unchanged", 8'h34);

    // R10 read data returns to zero
    rd(8'h00, d);
    chk("R10 read value", 64'(d), 64'(exp_sel(0)));
    @(negedge clk);
    chk("R10 idle rdata zero", 64'(bus_rdata), 64'd0);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 6);
      case (op)
        0: begin
          wr(8'(4 * ($urandom % 6)), $urandom);
          check_ports("R2 R3 random select");
        end
        1: begin
          wr(($urandom % 2) ? 8'h20 : 8'h1C, $urandom);
          check_ports("R4 R6 random set");
        end
        2: begin
          wr(($urandom % 2) ? 8'h2C : 8'h28, $urandom);
          check_ports("R5 R6 random clear");
        end
        3: begin
          logic [7:0] a = 8'(4 * ($urandom % 20));
          rd_chk($sformatf("R2 R7 R8 R9 random read %0h", a), a);
        end
        4: begin
          pin_in = {$urandom, $urandom};
          repeat (2) @(negedge clk);
        end
        default: begin
          wr(holes[$urandom % 5], $urandom);
          check_ports("R9 random hole write");
        end
      endcase
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule